// File: doc/BRIEF.md
# Register-Cached Dual Circular Stack

This block holds the operand and return stacks of a small stack processor. The operand stack keeps its two topmost values in registers, called top and second. Deeper values go into an eight-entry ring of storage that a wrapping pointer indexes. An ALU can therefore read both operands of a binary operation straight from registers, and no storage read sits in that path. The return stack keeps one top register in front of a ring of the same kind.

In each cycle the operand stack accepts one command: push, pop, replace the top, or pop-and-combine. In pop-and-combine, the top takes an external ALU result computed from top and second. The return stack accepts push or pop in the same cycle, and the two stacks do not interact. Nothing detects depth errors. Pushing past eight buried entries silently overwrites the oldest entry. Popping past the valid depth returns whatever the ring still holds.

Top module: `stack_pair`

## Requirements
- R1: Reset sets top, second, return top, both ring pointers and every ring entry to zero. Pops that follow a reset therefore deliver zeros.
- R2: An operand push stores the old second at the ring pointer and advances the pointer by one. Second takes the old top, and top takes `ds_din_i`.
- R3: An operand pop moves second into top and steps the pointer back by one. Second is then loaded from the ring entry at the new pointer.
- R4: A combine loads top with `ds_alu_i`. Second and the pointer change exactly as in a pop, so the depth drops by one.
- R5: A replace loads top with `ds_din_i`. Second and the pointer stay unchanged.
- R6: When several operand requests are active in one cycle, exactly one is carried out. The order of precedence is push, then pop, then combine, then replace. With no request active, all operand state holds.
- R7: Ring pointers count modulo 8. A push that finds the ring full overwrites the oldest entry, and no flag exists.
- R8: A pop beyond the valid depth returns stale ring contents. The pointer keeps wrapping, and no flag is raised.
- R9: A return push stores the old return top at the return pointer and advances that pointer. The return top takes `rs_din_i`.
- R10: A return pop steps the return pointer back and loads the return top from the ring entry at the new pointer. If push and pop are requested together, the push wins.
- R11: Operand and return commands issued in the same cycle both complete, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ds_push_i | input | 1 | Operand push request |
| ds_pop_i | input | 1 | Operand pop request |
| ds_comb_i | input | 1 | Operand pop-and-combine request |
| ds_repl_i | input | 1 | Replace-top request |
| ds_din_i | input | WIDTH | Value for operand push or replace |
| ds_alu_i | input | WIDTH | ALU result loaded into top by combine |
| ds_t_o | output | WIDTH | Operand top register |
| ds_s_o | output | WIDTH | Operand second register |
| rs_push_i | input | 1 | Return push request |
| rs_pop_i | input | 1 | Return pop request |
| rs_din_i | input | WIDTH | Value for return push |
| rs_r_o | output | WIDTH | Return top register |

## Verification
Two kinds of event can fall in the same cycle. Competing operand requests collide and must resolve by precedence, while an operand command and a return command run side by side and must not disturb each other. Both are provoked by sweeping all sixteen operand request patterns against all four return request patterns, with fresh data on every pass. Each cycle is judged by comparing top, second and return top against an arithmetic model of both rings, which also covers deliberate overflow and underflow runs.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_PUSH,
        DS_POP,
        DS_COMB,
        DS_REPL
    } ds_op_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_PUSH,
        RS_POP
    } rs_op_e;

endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
    import stk_pkg::*;
(
    input  logic   ds_push_i,
    input  logic   ds_pop_i,
    input  logic   ds_comb_i,
    input  logic   ds_repl_i,
    input  logic   rs_push_i,
    input  logic   rs_pop_i,
    output ds_op_e ds_op_o,
    output rs_op_e rs_op_o
);

    // Fixed precedence: push, pop, combine, replace.
    always_comb begin
        if (ds_push_i)      ds_op_o = DS_PUSH;
        else if (ds_pop_i)  ds_op_o = DS_POP;
        else if (ds_comb_i) ds_op_o = DS_COMB;
        else if (ds_repl_i) ds_op_o = DS_REPL;
        else                ds_op_o = DS_IDLE;
    end

    always_comb begin
        if (rs_push_i)     rs_op_o = RS_PUSH;
        else if (rs_pop_i) rs_op_o = RS_POP;
        else               rs_op_o = RS_IDLE;
    end

endmodule

// File: rtl/stk_ring.sv
module stk_ring #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] below_o,
    output logic [PW-1:0]    ptr_o
);

    typedef struct packed {
        logic [PW-1:0]                ptr;
        logic [DEPTH-1:0][WIDTH-1:0]  mem;
    } ring_t;

    ring_t st_d, st_q;

    // DEPTH is a power of two, so the pointer wraps by plain overflow.
    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.ptr] = wdata_i;
            st_d.ptr           = st_q.ptr + PW'(1);
        end else if (pop_i) begin
            st_d.ptr = st_q.ptr - PW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign below_o = st_q.mem[st_q.ptr - PW'(1)];
    assign ptr_o   = st_q.ptr;

endmodule

// File: rtl/stk_data_core.sv
module stk_data_core
    import stk_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  ds_op_e           op_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] alu_i,
    output logic [WIDTH-1:0] t_o,
    output logic [WIDTH-1:0] s_o,
    output logic [PW-1:0]    ptr_o
);

    typedef struct packed {
        logic [WIDTH-1:0] t;
        logic [WIDTH-1:0] s;
    } top_t;

    top_t st_d, st_q;
    logic             ring_push, ring_pop;
    logic [WIDTH-1:0] below;

    always_comb begin
        st_d      = st_q;
        ring_push = 1'b0;
        ring_pop  = 1'b0;
        unique case (op_i)
            DS_PUSH: begin
                ring_push = 1'b1;
                st_d.s    = st_q.t;
                st_d.t    = din_i;
            end
            DS_POP: begin
                ring_pop = 1'b1;
                st_d.t   = st_q.s;
                st_d.s   = below;
            end
            DS_COMB: begin
                ring_pop = 1'b1;
                st_d.t   = alu_i;
                st_d.s   = below;
            end
            DS_REPL: st_d.t = din_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    stk_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ring (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (ring_push),
        .pop_i   (ring_pop),
        .wdata_i (st_q.s),
        .below_o (below),
        .ptr_o   (ptr_o)
    );

    assign t_o = st_q.t;
    assign s_o = st_q.s;

endmodule

// File: rtl/stk_ret_core.sv
module stk_ret_core
    import stk_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  rs_op_e           op_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] r_o,
    output logic [PW-1:0]    ptr_o
);

    logic [WIDTH-1:0] r_d, r_q;
    logic             ring_push, ring_pop;
    logic [WIDTH-1:0] below;

    always_comb begin
        r_d       = r_q;
        ring_push = 1'b0;
        ring_pop  = 1'b0;
        unique case (op_i)
            RS_PUSH: begin
                ring_push = 1'b1;
                r_d       = din_i;
            end
            RS_POP: begin
                ring_pop = 1'b1;
                r_d      = below;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    stk_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ring (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (ring_push),
        .pop_i   (ring_pop),
        .wdata_i (r_q),
        .below_o (below),
        .ptr_o   (ptr_o)
    );

    assign r_o = r_q;

endmodule

// File: rtl/stack_pair.sv
module stack_pair
    import stk_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ds_push_i,
    input  logic             ds_pop_i,
    input  logic             ds_comb_i,
    input  logic             ds_repl_i,
    input  logic [WIDTH-1:0] ds_din_i,
    input  logic [WIDTH-1:0] ds_alu_i,
    output logic [WIDTH-1:0] ds_t_o,
    output logic [WIDTH-1:0] ds_s_o,
    input  logic             rs_push_i,
    input  logic             rs_pop_i,
    input  logic [WIDTH-1:0] rs_din_i,
    output logic [WIDTH-1:0] rs_r_o
);

    ds_op_e        ds_op;
    rs_op_e        rs_op;
    logic [PW-1:0] ds_ptr;
    logic [PW-1:0] rs_ptr;

    stk_op_decode i_decode (
        .ds_push_i (ds_push_i),
        .ds_pop_i  (ds_pop_i),
        .ds_comb_i (ds_comb_i),
        .ds_repl_i (ds_repl_i),
        .rs_push_i (rs_push_i),
        .rs_pop_i  (rs_pop_i),
        .ds_op_o   (ds_op),
        .rs_op_o   (rs_op)
    );

    stk_data_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_data (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (ds_op),
        .din_i  (ds_din_i),
        .alu_i  (ds_alu_i),
        .t_o    (ds_t_o),
        .s_o    (ds_s_o),
        .ptr_o  (ds_ptr)
    );

    stk_ret_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ret (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (rs_op),
        .din_i  (rs_din_i),
        .r_o    (rs_r_o),
        .ptr_o  (rs_ptr)
    );

endmodule

// File: rtl/stack_pair_chk.sv
module stack_pair_chk #(
    parameter int WIDTH = 18,
    parameter int PW    = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ds_push_i,
    input logic             ds_pop_i,
    input logic             ds_comb_i,
    input logic             ds_repl_i,
    input logic [WIDTH-1:0] ds_din_i,
    input logic [WIDTH-1:0] ds_alu_i,
    input logic [WIDTH-1:0] ds_t_o,
    input logic [WIDTH-1:0] ds_s_o,
    input logic             rs_push_i,
    input logic             rs_pop_i,
    input logic [WIDTH-1:0] rs_din_i,
    input logic [WIDTH-1:0] rs_r_o,
    input logic [PW-1:0]    ds_ptr,
    input logic [PW-1:0]    rs_ptr
);

    a_r2_push_shifts_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ds_push_i |=> (ds_t_o == $past(ds_din_i)) && (ds_s_o == $past(ds_t_o))
                      && (ds_ptr == PW'($past(ds_ptr) + 1'b1)));

    a_r3_pop_lifts_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ds_pop_i && !ds_push_i) |=> (ds_t_o == $past(ds_s_o))
                                     && (ds_ptr == PW'($past(ds_ptr) - 1'b1)));

    a_r4_combine_takes_alu: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ds_comb_i && !ds_push_i && !ds_pop_i) |=> (ds_t_o == $past(ds_alu_i))
                                     && (ds_ptr == PW'($past(ds_ptr) - 1'b1)));

    a_r5_replace_keeps_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ds_repl_i && !ds_push_i && !ds_pop_i && !ds_comb_i)
            |=> (ds_t_o == $past(ds_din_i)) && $stable(ds_s_o) && $stable(ds_ptr));

    a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ds_push_i || ds_pop_i || ds_comb_i || ds_repl_i)
            |=> $stable(ds_t_o) && $stable(ds_s_o) && $stable(ds_ptr));

    a_r9_rpush_loads_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rs_push_i |=> (rs_r_o == $past(rs_din_i)) && (rs_ptr == PW'($past(rs_ptr) + 1'b1)));

    a_r10_rpop_steps_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rs_pop_i && !rs_push_i) |=> (rs_ptr == PW'($past(rs_ptr) - 1'b1)));

    a_r11_ret_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rs_push_i || rs_pop_i) |=> $stable(rs_r_o) && $stable(rs_ptr));

endmodule

bind stack_pair stack_pair_chk #(.WIDTH(WIDTH), .PW(PW)) i_stack_pair_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ds_push_i (ds_push_i),
    .ds_pop_i  (ds_pop_i),
    .ds_comb_i (ds_comb_i),
    .ds_repl_i (ds_repl_i),
    .ds_din_i  (ds_din_i),
    .ds_alu_i  (ds_alu_i),
    .ds_t_o    (ds_t_o),
    .ds_s_o    (ds_s_o),
    .rs_push_i (rs_push_i),
    .rs_pop_i  (rs_pop_i),
    .rs_din_i  (rs_din_i),
    .rs_r_o    (rs_r_o),
    .ds_ptr    (ds_ptr),
    .rs_ptr    (rs_ptr)
);

// File: tb/test_stack_pair.sv
module test_stack_pair;

    localparam int W = 18;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ds_push = 0, ds_pop = 0, ds_comb = 0, ds_repl = 0;
    logic [W-1:0] ds_din = '0, ds_alu = '0;
    logic         rs_push = 0, rs_pop = 0;
    logic [W-1:0] rs_din = '0;
    logic [W-1:0] ds_t, ds_s, rs_r;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Reference model of both stacks
    logic [W-1:0] m_dmem [D];
    logic [W-1:0] m_rmem [D];
    int           m_dptr = 0, m_rptr = 0;
    logic [W-1:0] m_t = '0, m_s = '0, m_r = '0;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    stack_pair #(.WIDTH(W), .DEPTH(D)) i_stack_pair (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ds_push_i (ds_push),
        .ds_pop_i  (ds_pop),
        .ds_comb_i (ds_comb),
        .ds_repl_i (ds_repl),
        .ds_din_i  (ds_din),
        .ds_alu_i  (ds_alu),
        .ds_t_o    (ds_t),
        .ds_s_o    (ds_s),
        .rs_push_i (rs_push),
        .rs_pop_i  (rs_pop),
        .rs_din_i  (rs_din),
        .rs_r_o    (rs_r)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[W-1:0];
    endfunction

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input logic dpu, input logic dpo, input logic dco, input logic dre,
                        input logic rpu, input logic rpo,
                        input logic [W-1:0] din, input logic [W-1:0] alu,
                        input logic [W-1:0] rdin, input string dtag, input string rtag);
        string td, tr;
        ds_push = dpu; ds_pop = dpo; ds_comb = dco; ds_repl = dre;
        rs_push = rpu; rs_pop = rpo;
        ds_din = din; ds_alu = alu; rs_din = rdin;
        @(posedge clk);
        // operand model: push > pop > combine > replace
        if (dpu) begin
            m_dmem[m_dptr] = m_s; m_dptr = (m_dptr + 1) % D; m_s = m_t; m_t = din;
        end else if (dpo || dco) begin
            m_t = dpo ? m_s : alu; m_dptr = (m_dptr + D - 1) % D; m_s = m_dmem[m_dptr];
        end else if (dre) begin
            m_t = din;
        end
        if (rpu) begin
            m_rmem[m_rptr] = m_r; m_rptr = (m_rptr + 1) % D; m_r = rdin;
        end else if (rpo) begin
            m_rptr = (m_rptr + D - 1) % D; m_r = m_rmem[m_rptr];
        end
        @(negedge clk);
        td = dtag;
        if (td == "") begin
            if ((dpu + dpo + dco + dre) > 1) td = "R6";
            else if (dpu) td = "R2";
            else if (dpo) td = "R3";
            else if (dco) td = "R4";
            else if (dre) td = "R5";
            else td = "R11";
        end
        tr = rtag;
        if (tr == "") begin
            if (rpu && !rpo) tr = "R9";
            else if (rpo) tr = "R10";
            else tr = "R11";
        end
        check(td, "top", ds_t, m_t);
        check(td, "second", ds_s, m_s);
        check(tr, "return top", rs_r, m_r);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : stimulus
        for (int i = 0; i < D; i++) begin
            m_dmem[i] = '0;
            m_rmem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "top after reset", ds_t, '0);
        check("R1", "second after reset", ds_s, '0);
        check("R1", "return top after reset", rs_r, '0);
        // R1: ring cleared, so pops deliver zero
        for (int i = 0; i < 3; i++)
            step(0, 1, 0, 0, 0, 1, '0, '0, '0, "R1", "R1");

        // R7: overflow by pushing twelve values (ring holds eight below the tops)
        for (int i = 0; i < 12; i++)
            step(1, 0, 0, 0, 1, 0, W'(100 + i), '0, W'(300 + i), "R7", "R7");
        // R8: pop well beyond the valid depth, stale contents come back
        for (int i = 0; i < 14; i++)
            step(0, 1, 0, 0, 0, 1, '0, '0, '0, "R8", "R8");

        // Near-exhaustive sweep of all request combinations, both stacks at once
        for (int pass = 0; pass < 4; pass++) begin
            for (int dc = 0; dc < 16; dc++) begin
                for (int rc = 0; rc < 4; rc++) begin
                    logic [W-1:0] a, b, c;
                    a = next_rand(); b = next_rand(); c = next_rand();
                    step(dc[0], dc[1], dc[2], dc[3], rc[0], rc[1], a, b, c, "", "");
                end
            end
        end

        // R5 then R4: replace leaves depth alone, combine pulls from ring
        step(1, 0, 0, 0, 0, 0, W'(18'h2AAAA), '0, '0, "R2", "");
        step(0, 0, 0, 1, 0, 0, W'(18'h15555), '0, '0, "R5", "");
        step(0, 0, 1, 0, 0, 0, '0, W'(18'h3FFFF), '0, "R4", "");
        step(0, 0, 0, 0, 0, 0, '0, '0, '0, "R6", "R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule